// File: doc/BRIEF.md
# UART Interrupt Identification and Clearing Logic

This block decides, for one UART channel, which pending interrupt source the host sees and when each source stops being pending. Seven sources are ranked. Some are held in sticky latches that clear on a particular register access. Others follow a live condition. The block presents a 6-bit identification code for the highest-ranked source that is both pending and enabled, together with an interrupt request line.

The serial engine, the FIFOs, the baud generator and the receive timeout counter are outside this block. They reach it as flag, level and pulse inputs. The host register file reaches it as single-cycle access strobes. Both outputs are registered and reflect the inputs of the previous clock. A read of the identification register acts on the code the host sees in that same cycle.

Top module: `uart_int_ident`

## Requirements
- R1: Priority, from highest to lowest, with codes written as bit 5 down to bit 0: level 1 line status 000110, level 2 receive timeout 001100, level 3 receive ready 000100, level 4 transmit ready 000010, level 5 modem status 000000, level 6 Xoff/special character 010000, level 7 CTS/RTS change 100000. The code shows the highest level that is both pending and enabled.
- R2: When nothing is pending and enabled, the code is 000001 and `irq_o` is low. Otherwise `irq_o` is high.
- R3: Line status becomes pending when any bit of `line_err_i[3:0]` goes from 0 to 1. A strobe on `rd_line_i` clears it. An identification read does not clear it, and error bits that stay high do not raise it again.
- R4: Receive ready has no latch. It is pending exactly while `rx_hit_i` (FIFO level at or above the trigger) is high.
- R5: Receive timeout becomes pending on a `rx_tmo_i` pulse. A strobe on `rd_rxdata_i` clears it, and an identification read does not.
- R6: Transmit ready becomes pending when `tx_empty_i` rises. A write strobe on `wr_txdata_i` clears it, and so does an identification read made while the code shows 000010.
- R7: Modem status becomes pending when any bit of `msr_chg_i[3:0]` goes from 0 to 1. A strobe on `rd_modem_i` clears it.
- R8: The Xoff latch is set by `xoff_det_i`. It is cleared by `xon_det_i` or by an identification read made while the code shows 010000. The special-character latch is set by `spec_det_i`. It is cleared by the same identification read, or by a later `rx_char_i` strobe. A strobe in the same cycle as the detection does not clear it.
- R9: A CTS/RTS change becomes pending on a 0-to-1 edge of `cts_i` only while `auto_cts_en_i` is set, and on a 0-to-1 edge of `rts_i` only while `auto_rts_en_i` is set. Turning the enable on while the pin is already high raises nothing. A strobe on `rd_modem_i` clears it.
- R10: Bit k-1 of `src_en_i` enables level k. A disabled source is absent from the code and from `irq_o`, but it stays pending and appears once it is enabled.
- R11: An identification read clears only the source named by the code visible in that cycle. When a set event and a clear arrive in the same cycle, the source stays pending.
- R12: Both outputs are registered. An input change in one cycle shows at the outputs after the next rising clock edge.
- R13: A synchronous active-high `rst` clears every latch and sets the code to 000001 with `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | 7 | Per-level enables, bit k-1 for level k |
| line_err_i | input | 4 | Line error flags |
| rx_hit_i | input | 1 | Receive FIFO level at or above trigger |
| rx_tmo_i | input | 1 | Receive timeout expiry pulse |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| msr_chg_i | input | 4 | Modem change flags |
| xoff_det_i | input | 1 | Xoff character received pulse |
| xon_det_i | input | 1 | Xon character received pulse |
| spec_det_i | input | 1 | Special character received pulse |
| rx_char_i | input | 1 | Any character received pulse |
| cts_i | input | 1 | Clear-to-send pin level |
| rts_i | input | 1 | Request-to-send pin level |
| auto_cts_en_i | input | 1 | Automatic CTS flow control enable |
| auto_rts_en_i | input | 1 | Automatic RTS flow control enable |
| rd_stat_i | input | 1 | Identification register read strobe |
| rd_line_i | input | 1 | Line status read strobe |
| rd_modem_i | input | 1 | Modem status read strobe |
| rd_rxdata_i | input | 1 | Receive data read strobe |
| wr_txdata_i | input | 1 | Transmit data write strobe |
| int_id_o | output | 6 | Interrupt identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
A sticky latch that fails to set or clear shows up at the ports one clock after the triggering input. The code either keeps naming a source the host has already serviced, or it falls through to a lower level or to 000001. A wrong identification read can clear the wrong latch, and that is visible only when a second pending source exists. For this reason the bench pairs sources and reads the code twice in a row. The priority and enable logic is swept over every combination of pending sources and enables, so any ranking or masking error appears as a wrong code on the cycle after the enables change.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
   localparam int NUM_LVL = 7;
   localparam int CODE_W  = 6;
   typedef logic [CODE_W-1:0] code_t;

   localparam code_t CODE_NONE  = 6'b000001;
   localparam code_t CODE_LINE  = 6'b000110;
   localparam code_t CODE_TMO   = 6'b001100;
   localparam code_t CODE_RXRDY = 6'b000100;
   localparam code_t CODE_TXRDY = 6'b000010;
   localparam code_t CODE_MODEM = 6'b000000;
   localparam code_t CODE_XSPEC = 6'b010000;
   localparam code_t CODE_FLOW  = 6'b100000;

   // index 0 is level 1 (highest priority)
   function automatic code_t lvl_code(input int idx);
      case (idx)
         0:       return CODE_LINE;
         1:       return CODE_TMO;
         2:       return CODE_RXRDY;
         3:       return CODE_TXRDY;
         4:       return CODE_MODEM;
         5:       return CODE_XSPEC;
         6:       return CODE_FLOW;
         default: return CODE_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irq_flag_latch.sv
module irq_flag_latch #(
   parameter int W    = 1,
   parameter bit EDGE = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ev_i,
   input  logic [W-1:0] en_i,
   input  logic         clr_i,
   output logic         pend_nx_o
);
   logic pend_q;
   logic set_w;

   if (W < 1 || W > 16) begin : g_bad_w
      $error("irq_flag_latch: W out of range");
   end

   if (EDGE) begin : g_edge
      logic [W-1:0] prev_q;
      always_ff @(posedge clk) begin
         prev_q <= ev_i;
      end
      assign set_w = |(ev_i & ~prev_q & en_i);
   end else begin : g_pulse
      assign set_w = |(ev_i & en_i);
   end

   assign pend_nx_o = set_w | (pend_q & ~clr_i);

   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= pend_nx_o;
   end

   // R11: a set event wins over a clear in the same cycle
   a_r11_set_holds: assert property (@(posedge clk) disable iff (rst)
      set_w |=> pend_q);
   a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_w) |=> !pend_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_int_pkg::*;
#(
   parameter int N = NUM_LVL
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] en_i,
   output code_t        code_o,
   output logic         any_o
);
   if (N != NUM_LVL) begin : g_bad_n
      $error("irq_prio_enc: N must match the level count");
   end

   logic [N-1:0] act_w;
   assign act_w = pend_i & en_i;
   assign any_o = |act_w;

   always_comb begin
      code_o = CODE_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (act_w[i]) code_o = lvl_code(i);
      end
   end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
   import uart_int_pkg::*;
#(
   parameter int LINE_W  = 4,
   parameter int MODEM_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_LVL-1:0] src_en_i,
   input  logic [LINE_W-1:0]  line_err_i,
   input  logic               rx_hit_i,
   input  logic               rx_tmo_i,
   input  logic               tx_empty_i,
   input  logic [MODEM_W-1:0] msr_chg_i,
   input  logic               xoff_det_i,
   input  logic               xon_det_i,
   input  logic               spec_det_i,
   input  logic               rx_char_i,
   input  logic               cts_i,
   input  logic               rts_i,
   input  logic               auto_cts_en_i,
   input  logic               auto_rts_en_i,
   input  logic               rd_stat_i,
   input  logic               rd_line_i,
   input  logic               rd_modem_i,
   input  logic               rd_rxdata_i,
   input  logic               wr_txdata_i,
   output logic [CODE_W-1:0]  int_id_o,
   output logic               irq_o
);
   if (LINE_W < 1 || MODEM_W < 1) begin : g_bad_cfg
      $error("uart_int_ident: flag widths must be positive");
   end

   code_t              code_q;
   logic               irq_q;
   logic [NUM_LVL-1:0] pend_nx;
   code_t              enc_code;
   logic               enc_any;
   logic               line_nx, tmo_nx, tx_nx, mdm_nx, xoff_nx, spec_nx, flow_nx;
   logic               stat_tx, stat_xs;

   // identification read acts on the code the host sees this cycle
   assign stat_tx = rd_stat_i && (code_q == CODE_TXRDY);
   assign stat_xs = rd_stat_i && (code_q == CODE_XSPEC);

   irq_flag_latch #(.W(LINE_W), .EDGE(1'b1)) u_line (
      .clk(clk), .rst(rst), .ev_i(line_err_i), .en_i({LINE_W{1'b1}}),
      .clr_i(rd_line_i), .pend_nx_o(line_nx));

   irq_flag_latch #(.W(1), .EDGE(1'b0)) u_tmo (
      .clk(clk), .rst(rst), .ev_i(rx_tmo_i), .en_i(1'b1),
      .clr_i(rd_rxdata_i), .pend_nx_o(tmo_nx));

   irq_flag_latch #(.W(1), .EDGE(1'b1)) u_tx (
      .clk(clk), .rst(rst), .ev_i(tx_empty_i), .en_i(1'b1),
      .clr_i(wr_txdata_i | stat_tx), .pend_nx_o(tx_nx));

   irq_flag_latch #(.W(MODEM_W), .EDGE(1'b1)) u_mdm (
      .clk(clk), .rst(rst), .ev_i(msr_chg_i), .en_i({MODEM_W{1'b1}}),
      .clr_i(rd_modem_i), .pend_nx_o(mdm_nx));

   irq_flag_latch #(.W(1), .EDGE(1'b0)) u_xoff (
      .clk(clk), .rst(rst), .ev_i(xoff_det_i), .en_i(1'b1),
      .clr_i(xon_det_i | stat_xs), .pend_nx_o(xoff_nx));

   irq_flag_latch #(.W(1), .EDGE(1'b0)) u_spec (
      .clk(clk), .rst(rst), .ev_i(spec_det_i), .en_i(1'b1),
      .clr_i(rx_char_i | stat_xs), .pend_nx_o(spec_nx));

   irq_flag_latch #(.W(2), .EDGE(1'b1)) u_flow (
      .clk(clk), .rst(rst), .ev_i({rts_i, cts_i}),
      .en_i({auto_rts_en_i, auto_cts_en_i}),
      .clr_i(rd_modem_i), .pend_nx_o(flow_nx));

   assign pend_nx = {flow_nx, xoff_nx | spec_nx, mdm_nx, tx_nx,
                     rx_hit_i, tmo_nx, line_nx};

   irq_prio_enc #(.N(NUM_LVL)) u_enc (
      .pend_i(pend_nx), .en_i(src_en_i), .code_o(enc_code), .any_o(enc_any));

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= CODE_NONE;
         irq_q  <= 1'b0;
      end else begin
         code_q <= enc_code;
         irq_q  <= enc_any;
      end
   end

   assign int_id_o = code_q;
   assign irq_o    = irq_q;

   // R13: reset leaves the idle code and no request
   a_r13_reset_idle: assert property (@(posedge clk)
      rst |=> (int_id_o == CODE_NONE && !irq_o));
   // R2: request high exactly when a source code is shown
   a_r2_irq_code: assert property (@(posedge clk) disable iff (rst)
      irq_o == (int_id_o != CODE_NONE));
   // R1: an enabled line-status event always wins
   a_r1_line_first: assert property (@(posedge clk) disable iff (rst)
      (line_nx && src_en_i[0]) |=> (int_id_o == CODE_LINE));
   // R4: receive ready follows the level when nothing higher is active
   a_r4_rx_level: assert property (@(posedge clk) disable iff (rst)
      (rx_hit_i && src_en_i[2] && !(line_nx && src_en_i[0]) &&
       !(tmo_nx && src_en_i[1])) |=> (int_id_o == CODE_RXRDY));
endmodule

// File: tb/uart_int_ident_tb.sv
module uart_int_ident_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [6:0] src_en = 7'h7f;
   logic [3:0] line_err = '0, msr_chg = '0;
   logic rx_hit = 0, rx_tmo = 0, tx_empty = 0, xoff_det = 0, xon_det = 0;
   logic spec_det = 0, rx_char = 0, cts = 0, rts = 0, acts = 0, arts = 0;
   logic rd_stat = 0, rd_line = 0, rd_modem = 0, rd_rxdata = 0, wr_txdata = 0;
   logic [5:0] int_id;
   logic       irq;
   int n_chk = 0, n_fail = 0;

   localparam logic [5:0] NONE = 6'b000001, LINE = 6'b000110, TMO = 6'b001100;
   localparam logic [5:0] RXR = 6'b000100, TXR = 6'b000010, MDM = 6'b000000;
   localparam logic [5:0] XSP = 6'b010000, FLW = 6'b100000;

   always #4 clk = ~clk;

   uart_int_ident dut_i (
      .clk(clk), .rst(rst), .src_en_i(src_en), .line_err_i(line_err),
      .rx_hit_i(rx_hit), .rx_tmo_i(rx_tmo), .tx_empty_i(tx_empty),
      .msr_chg_i(msr_chg), .xoff_det_i(xoff_det), .xon_det_i(xon_det),
      .spec_det_i(spec_det), .rx_char_i(rx_char), .cts_i(cts), .rts_i(rts),
      .auto_cts_en_i(acts), .auto_rts_en_i(arts), .rd_stat_i(rd_stat),
      .rd_line_i(rd_line), .rd_modem_i(rd_modem), .rd_rxdata_i(rd_rxdata),
      .wr_txdata_i(wr_txdata), .int_id_o(int_id), .irq_o(irq));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [5:0] exp_code);
      n_chk++;
      if (int_id !== exp_code || irq !== (exp_code != NONE)) begin
         n_fail++;
         $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                  req, int_id, irq, exp_code, exp_code != NONE);
      end
   endtask

   function automatic logic [5:0] exp_of(input logic [6:0] act);
      logic [5:0] t [7] = '{LINE, TMO, RXR, TXR, MDM, XSP, FLW};
      for (int i = 0; i < 7; i++) if (act[i]) return t[i];
      return NONE;
   endfunction

   task automatic do_reset();
      rst = 1; line_err = 0; msr_chg = 0; rx_hit = 0; rx_tmo = 0; tx_empty = 0;
      xoff_det = 0; xon_det = 0; spec_det = 0; rx_char = 0; cts = 0; rts = 0;
      acts = 0; arts = 0; src_en = 7'h7f;
      step(); step();
      rst = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      chk("R13 reset state", NONE);
      step();
      chk("R2 idle with nothing pending", NONE);

      // R1/R10 sweep: every pending set against every enable mask
      for (int m = 0; m < 128; m++) begin
         do_reset();
         acts = 1;
         line_err = {3'b0, m[0]}; rx_tmo = m[1]; rx_hit = m[2]; tx_empty = m[3];
         msr_chg = {m[4], 3'b0}; xoff_det = m[5]; cts = m[6];
         step();
         line_err = 0; rx_tmo = 0; msr_chg = 0; xoff_det = 0; cts = 0;
         step();
         for (int e = 0; e < 128; e++) begin
            src_en = 7'(e);
            step();
            chk("R1 R10 priority sweep", exp_of(7'(m) & 7'(e)));
         end
      end

      // R3 line status
      do_reset();
      line_err = 4'b0100; step(); chk("R3 line error raises", LINE);
      rd_stat = 1; step(); rd_stat = 0; chk("R3 stat read keeps line", LINE);
      rd_line = 1; step(); rd_line = 0; chk("R3 line read clears", NONE);
      step(); chk("R3 held flag no re-raise", NONE);
      line_err = 4'b0110; step(); chk("R3 new flag raises again", LINE);
      rd_line = 1; step(); rd_line = 0; line_err = 0;

      // R5 timeout
      rx_tmo = 1; step(); rx_tmo = 0; chk("R5 timeout raises", TMO);
      rd_stat = 1; step(); rd_stat = 0; chk("R5 stat read keeps timeout", TMO);
      rd_rxdata = 1; step(); rd_rxdata = 0; chk("R5 data read clears", NONE);

      // R4 receive ready level
      rx_hit = 1; step(); chk("R4 level raises", RXR);
      rd_stat = 1; step(); rd_stat = 0; chk("R4 stat read no effect", RXR);
      rx_hit = 0; step(); chk("R4 level drop clears", NONE);

      // R6 transmit ready, R12 one-clock latency
      tx_empty = 1; #2; chk("R12 no change before edge", NONE);
      step(); chk("R6 empty raises", TXR);
      rd_stat = 1; step(); rd_stat = 0; chk("R6 stat read clears", NONE);
      tx_empty = 0; step(); tx_empty = 1; step(); chk("R6 second empty", TXR);
      wr_txdata = 1; step(); wr_txdata = 0; chk("R6 write clears", NONE);

      // R11 read clears only the reported source
      tx_empty = 0; step();
      tx_empty = 1; xoff_det = 1; step(); xoff_det = 0;
      chk("R11 tx above xoff", TXR);
      rd_stat = 1; step(); chk("R11 first read leaves xoff", XSP);
      step(); rd_stat = 0; chk("R11 second read clears xoff", NONE);
      xoff_det = 1; step(); xoff_det = 0;
      rd_stat = 1; xoff_det = 1; step(); rd_stat = 0; xoff_det = 0;
      chk("R11 set during read stays", XSP);

      // R8 xon and next character
      xon_det = 1; step(); xon_det = 0; chk("R8 xon clears xoff", NONE);
      spec_det = 1; rx_char = 1; step(); spec_det = 0; rx_char = 0;
      chk("R8 own char keeps special", XSP);
      rx_char = 1; step(); rx_char = 0; chk("R8 next char clears special", NONE);

      // R7 modem status
      msr_chg = 4'b0001; step(); chk("R7 modem change raises", MDM);
      rd_modem = 1; step(); rd_modem = 0; chk("R7 modem read clears", NONE);
      msr_chg = 0;

      // R9 flow-control edges
      cts = 1; step(); chk("R9 cts edge ignored when disabled", NONE);
      acts = 1; step(); chk("R9 enable on high pin no event", NONE);
      cts = 0; step(); cts = 1; step(); chk("R9 cts edge raises", FLW);
      rd_modem = 1; step(); rd_modem = 0; chk("R9 modem read clears", NONE);
      rts = 1; step(); chk("R9 rts edge ignored when disabled", NONE);
      rts = 0; arts = 1; step(); rts = 1; step(); chk("R9 rts edge raises", FLW);
      rd_modem = 1; step(); rd_modem = 0;

      // R10 disabled source stays pending
      src_en = 7'b1110111; tx_empty = 0; step(); tx_empty = 1; step();
      chk("R10 disabled tx hidden", NONE);
      src_en = 7'h7f; step(); chk("R10 enabled tx appears", TXR);

      // R13 reset clears latches
      rst = 1; step(); rst = 0; chk("R13 reset clears pending", NONE);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule